// File: doc/BRIEF.md
# Two-Wire Serial Memory Target Controller

This block is the bus side of a 4096-byte serial memory. It samples open-drain clock and data lines with a fast system clock, finds start and stop conditions, shifts in the device address and a two-byte word address, and pulls the data line low to acknowledge or to send read data. Write bytes do not go into the array directly. Each one is handed to a separate page-write engine together with its target address. A one-cycle commit strobe at the stop condition tells that engine to begin its internal write. While the engine reports busy, the block refuses its device address, so a host can poll until the write has finished.

Reads come straight from the array through a combinational read port. The block keeps one internal address pointer. A write-direction word address sets it. Each byte sent advances it. Each byte written leaves it at the next location in the page. A read-direction command without a word address, called a current read, resumes from that pointer. A read continues byte by byte for as long as the host acknowledges.

Top module: `serial_mem_target`

## Requirements
- R1: A device-address byte is acknowledged only when bits 7..1 equal 1010000 and the engine is idle. Bit 0 selects the direction, with 0 for write and 1 for read. To acknowledge, SDA is held low through the ninth clock.
- R2: A device address that does not match gets no acknowledge. The block then leaves SDA released and ignores every later bit until the next start, so no write byte is handed on.
- R3: After a matching write-direction address, two word-address bytes follow, each acknowledged. Only the low 12 bits count, and bits 7..4 of the first byte are ignored.
- R4: Each data byte after the word address is acknowledged. It is presented for one cycle on the write port, and the write-first flag is set on the first byte of the command. A stop that follows at least one data byte gives a one-cycle commit strobe.
- R5: Successive write bytes keep address bits 11..5. Bits 4..0 count up and wrap within the 32-byte page, so 0x01E, 0x01F, 0x000, 0x001 follow one another.
- R6: A random read returns the byte at the given word address. It is a write-direction address plus the word address, then a repeated start and a read-direction address.
- R7: A current read returns the byte one past the last byte read. After a write, it returns the byte at the page-wrapped address following the last byte written.
- R8: In a read, a low acknowledge from the host after bit 0 makes the block send the next byte, with the address wrapping from 0xFFF to 0x000. A high acknowledge makes the block release SDA and wait for a stop.
- R9: While the engine is busy, the device address is not acknowledged. Once the engine is idle, the device address is acknowledged again.
- R10: A start followed by a stop during command input aborts the command. No commit is issued and the array is unchanged.
- R11: SDA changes only while SCL is low, after a falling edge, and it is released after a stop.
- R12: In reset, SDA is released and no write or commit strobe is given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_low_o | output | 1 | 1 pulls SDA low; 0 releases it |
| rd_addr_o | output | 12 | Internal address pointer, used as the array read address |
| rd_data_i | input | 8 | Array byte at rd_addr_o |
| wr_valid_o | output | 1 | One-cycle strobe for a received write byte |
| wr_first_o | output | 1 | Marks the first write byte of a command |
| wr_addr_o | output | 12 | Target address of the write byte |
| wr_data_o | output | 8 | Write byte value |
| wr_commit_o | output | 1 | One-cycle strobe at stop: start the internal write |
| wr_busy_i | input | 1 | Page-write engine is writing |

## Verification
The block sees every line change two system clocks late, and it registers its answer on the next clock. So SDA, the write strobes and the commit strobe follow the SCL fall, or the SDA rise of a stop, by three system clocks. The bench holds each SCL phase for six system clocks and samples SDA at the end of the high phase. By then an acknowledge or data bit started at the previous falling edge has settled, and the master's own data changes stay clear of the two-cycle sampling delay. Write strobes and commits are counted on every clock by a monitor. Array contents are checked only after acknowledge polling shows the engine idle, because the array changes only when the engine's busy window closes.

// File: rtl/serial_mem_target.sv
`timescale 1ns/1ps
module serial_mem_target #(
  parameter logic [6:0] DEV_ID = 7'b1010000,
  parameter int AW = 12,
  parameter int PW = 5,
  parameter int SYNC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_low_o,
  output logic [AW-1:0] rd_addr_o,
  input  logic [7:0]    rd_data_i,
  output logic          wr_valid_o,
  output logic          wr_first_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [7:0]    wr_data_o,
  output logic          wr_commit_o,
  input  logic          wr_busy_i
);
  localparam int HW = AW - 8;

  typedef enum logic [2:0] {S_IDLE, S_DEV, S_WHI, S_WLO, S_DATA, S_READ, S_SKIP} st_t;

  logic [SYNC:0] scl_p, sda_p;
  logic scl_c, scl_l, sda_c, sda_l;
  logic start_det, stop_det, scl_rise, scl_fall, live;
  st_t state;
  logic [3:0] cnt;
  logic in_ack, m_ack, have_data, sda_low;
  logic [7:0] shreg, tx;
  logic [HW-1:0] wa_hi;
  logic [AW-1:0] ptr, waddr, waddr_nx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= '1;
      sda_p <= '1;
    end else begin
      scl_p <= {scl_p[SYNC-1:0], scl_i};
      sda_p <= {sda_p[SYNC-1:0], sda_i};
    end
  end

  assign scl_c = scl_p[SYNC-1];
  assign scl_l = scl_p[SYNC];
  assign sda_c = sda_p[SYNC-1];
  assign sda_l = sda_p[SYNC];

  assign start_det = scl_c && scl_l && sda_l && !sda_c;
  assign stop_det  = scl_c && scl_l && !sda_l && sda_c;
  assign scl_rise  = scl_c && !scl_l;
  assign scl_fall  = !scl_c && scl_l;
  assign live      = (state != S_IDLE) && (state != S_SKIP);
  assign waddr_nx  = {waddr[AW-1:PW], waddr[PW-1:0] + PW'(1)};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      cnt         <= '0;
      in_ack      <= 1'b0;
      m_ack       <= 1'b0;
      have_data   <= 1'b0;
      sda_low     <= 1'b0;
      shreg       <= '0;
      tx          <= '0;
      wa_hi       <= '0;
      ptr         <= '0;
      waddr       <= '0;
      wr_valid_o  <= 1'b0;
      wr_first_o  <= 1'b0;
      wr_addr_o   <= '0;
      wr_data_o   <= '0;
      wr_commit_o <= 1'b0;
    end else begin
      wr_valid_o  <= 1'b0;
      wr_commit_o <= 1'b0;
      if (start_det) begin
        state   <= S_DEV;
        cnt     <= '0;
        in_ack  <= 1'b0;
        sda_low <= 1'b0;
      end else if (stop_det) begin
        if (state == S_DATA && have_data) wr_commit_o <= 1'b1;
        state     <= S_IDLE;
        in_ack    <= 1'b0;
        have_data <= 1'b0;
        sda_low   <= 1'b0;
      end else if (live && scl_rise) begin
        if (!in_ack && cnt < 4'd8) begin
          shreg <= {shreg[6:0], sda_c};
          cnt   <= cnt + 4'd1;
        end else if (in_ack && state == S_READ) begin
          m_ack <= !sda_c;
        end
      end else if (live && scl_fall) begin
        if (!in_ack && cnt == 4'd8) begin
          in_ack <= 1'b1;
          case (state)
            S_DEV: begin
              if (shreg[7:1] == DEV_ID && !wr_busy_i) begin
                sda_low <= 1'b1;
                m_ack   <= 1'b1;
                state   <= shreg[0] ? S_READ : S_WHI;
              end else begin
                state <= S_SKIP;
              end
            end
            S_WHI: begin
              sda_low <= 1'b1;
              wa_hi   <= shreg[HW-1:0];
              state   <= S_WLO;
            end
            S_WLO: begin
              sda_low   <= 1'b1;
              ptr       <= {wa_hi, shreg};
              waddr     <= {wa_hi, shreg};
              have_data <= 1'b0;
              state     <= S_DATA;
            end
            S_DATA: begin
              sda_low    <= 1'b1;
              wr_valid_o <= 1'b1;
              wr_first_o <= !have_data;
              wr_addr_o  <= waddr;
              wr_data_o  <= shreg;
              have_data  <= 1'b1;
              waddr      <= waddr_nx;
              ptr        <= waddr_nx;
            end
            S_READ: begin
              sda_low <= 1'b0;
              ptr     <= ptr + AW'(1);
            end
            default: ;
          endcase
        end else if (in_ack) begin
          in_ack <= 1'b0;
          cnt    <= '0;
          if (state == S_READ) begin
            if (m_ack) begin
              tx      <= rd_data_i;
              sda_low <= !rd_data_i[7];
            end else begin
              state   <= S_SKIP;
              sda_low <= 1'b0;
            end
          end else begin
            sda_low <= 1'b0;
          end
        end else if (state == S_READ) begin
          tx      <= {tx[6:0], 1'b0};
          sda_low <= !tx[6];
        end
      end
    end
  end

  assign sda_low_o = sda_low;
  assign rd_addr_o = ptr;
endmodule

module serial_mem_target_chk #(
  parameter int AW = 12,
  parameter int PW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          scl_q,
  input logic          stop_q,
  input logic          sda_low,
  input logic          wr_busy,
  input logic          wr_valid,
  input logic          wr_first,
  input logic [AW-1:0] wr_addr,
  input logic          wr_commit
);
  logic          seen;
  logic [AW-1:0] last_wa;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen    <= 1'b0;
      last_wa <= '0;
    end else if (wr_valid) begin
      seen    <= 1'b1;
      last_wa <= wr_addr;
    end
  end

  assert_sda_on_low_scl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_low != $past(sda_low)) |-> !$past(scl_q));

  assert_release_at_stop_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(stop_q) |-> !sda_low);

  assert_valid_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> !wr_valid);

  assert_commit_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |=> !wr_commit);

  assert_page_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_first && seen) |->
      (wr_addr[AW-1:PW] == last_wa[AW-1:PW] && wr_addr[PW-1:0] == last_wa[PW-1:0] + PW'(1)));

  assert_busy_nack_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_low) |-> !$past(wr_busy));
endmodule

bind serial_mem_target serial_mem_target_chk #(.AW(AW), .PW(PW)) chk_i (
  .clk(clk), .rst_n(rst_n), .scl_q(scl_c), .stop_q(stop_det), .sda_low(sda_low),
  .wr_busy(wr_busy_i), .wr_valid(wr_valid_o), .wr_first(wr_first_o),
  .wr_addr(wr_addr_o), .wr_commit(wr_commit_o)
);

// File: tb/serial_mem_target_tb_top.sv
`timescale 1ns/1ps
module serial_mem_target_tb_top;
  localparam int T = 6;
  localparam int BUSY = 600;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0, scl_m = 1'b1, sda_m = 1'b1;
  logic sda_low, wr_valid, wr_first, wr_commit;
  logic busy = 1'b0;
  logic [11:0] rd_addr, wr_addr;
  logic [7:0] rd_data, wr_data;
  wire sda_bus = sda_m & ~sda_low;

  int checks = 0, errors = 0, n_valid = 0, n_commit = 0, n_r11 = 0, busy_cnt = 0, pb_n = 0;
  bit finished = 1'b0, ptr_ok = 1'b0;
  logic sda_prev = 1'b0;
  logic [7:0] mem [0:4095];
  logic [7:0] exp_m [0:4095];
  logic [11:0] pb_a [0:31];
  logic [7:0] pb_d [0:31];
  logic [7:0] wbuf [0:31];
  logic [11:0] exp_ptr = '0;

  assign rd_data = mem[rd_addr];

  serial_mem_target dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_low_o(sda_low),
    .rd_addr_o(rd_addr), .rd_data_i(rd_data), .wr_valid_o(wr_valid), .wr_first_o(wr_first),
    .wr_addr_o(wr_addr), .wr_data_o(wr_data), .wr_commit_o(wr_commit), .wr_busy_i(busy)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 4096; i++) mem[i] <= 8'hFF;
      pb_n <= 0; busy <= 1'b0; busy_cnt <= 0;
    end else begin
      if (wr_valid) begin
        n_valid <= n_valid + 1;
        if (wr_first) begin
          pb_a[0] <= wr_addr; pb_d[0] <= wr_data; pb_n <= 1;
        end else if (pb_n < 32) begin
          pb_a[pb_n] <= wr_addr; pb_d[pb_n] <= wr_data; pb_n <= pb_n + 1;
        end
      end
      if (wr_commit) begin
        busy <= 1'b1; busy_cnt <= BUSY; n_commit <= n_commit + 1;
      end else if (busy) begin
        if (busy_cnt == 1) begin
          for (int i = 0; i < 32; i++) if (i < pb_n) mem[pb_a[i]] <= pb_d[i];
          busy <= 1'b0;
        end
        busy_cnt <= busy_cnt - 1;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && (sda_low !== sda_prev) && scl_m) n_r11 <= n_r11 + 1;
    sda_prev <= sda_low;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic start_c();
    sda_m = 1'b1; tick(T); scl_m = 1'b1; tick(T); sda_m = 1'b0; tick(T); scl_m = 1'b0; tick(T);
  endtask

  task automatic stop_c();
    sda_m = 1'b0; tick(T); scl_m = 1'b1; tick(T); sda_m = 1'b1; tick(T);
  endtask

  task automatic send_bit(input bit b);
    sda_m = b; tick(T); scl_m = 1'b1; tick(T); scl_m = 1'b0; tick(T);
  endtask

  task automatic get_bit(output bit b);
    sda_m = 1'b1; tick(T); scl_m = 1'b1; tick(T); b = sda_bus; scl_m = 1'b0; tick(T);
  endtask

  task automatic send_byte(input logic [7:0] d, output bit ack);
    bit b;
    for (int i = 7; i >= 0; i--) send_bit(d[i]);
    get_bit(b);
    ack = !b;
  endtask

  task automatic get_byte(output logic [7:0] d, input bit nack);
    bit b;
    for (int i = 7; i >= 0; i--) begin get_bit(b); d[i] = b; end
    send_bit(nack);
  endtask

  function automatic logic [11:0] pnext(input logic [11:0] x);
    return {x[11:5], x[4:0] + 5'd1};
  endfunction

  task automatic wait_ready(output int polls);
    bit a;
    polls = 0;
    do begin
      start_c(); send_byte(8'hA0, a); stop_c(); polls++;
    end while (!a && polls < 200);
  endtask

  task automatic do_write(input logic [15:0] a, input int n);
    bit k; int p; logic [11:0] x;
    wait_ready(p);
    start_c();
    send_byte(8'hA0, k); check(k, "R1 write address ack", k, 1);
    send_byte(a[15:8], k); check(k, "R3 word address high ack", k, 1);
    send_byte(a[7:0], k);  check(k, "R3 word address low ack", k, 1);
    x = a[11:0];
    for (int i = 0; i < n; i++) begin
      send_byte(wbuf[i], k); check(k, "R4 data byte ack", k, 1);
      exp_m[x] = wbuf[i];
      x = pnext(x);
    end
    stop_c();
    check(sda_low == 1'b0, "R11 released after stop", sda_low, 0);
    exp_ptr = x; ptr_ok = 1'b1;
  endtask

  task automatic do_rread(input logic [15:0] a, input int n, input string req);
    bit k; int p; logic [11:0] x; logic [7:0] d;
    wait_ready(p);
    start_c();
    send_byte(8'hA0, k); check(k, "R1 write address ack", k, 1);
    send_byte(a[15:8], k); check(k, "R3 word address high ack", k, 1);
    send_byte(a[7:0], k);  check(k, "R3 word address low ack", k, 1);
    start_c();
    send_byte(8'hA1, k); check(k, "R1 read address ack", k, 1);
    x = a[11:0];
    for (int i = 0; i < n; i++) begin
      get_byte(d, i == n - 1);
      check(d == exp_m[x], req, d, exp_m[x]);
      x = x + 12'd1;
    end
    stop_c();
    exp_ptr = x; ptr_ok = 1'b1;
  endtask

  task automatic do_cread(input int n, input string req);
    bit k; int p; logic [11:0] x; logic [7:0] d;
    wait_ready(p);
    start_c();
    send_byte(8'hA1, k); check(k, "R1 read address ack", k, 1);
    x = exp_ptr;
    for (int i = 0; i < n; i++) begin
      get_byte(d, i == n - 1);
      check(d == exp_m[x], req, d, exp_m[x]);
      x = x + 12'd1;
    end
    stop_c();
    exp_ptr = x;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog R12 actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    bit k, b;
    int p, vc, cc, op, n, seed;
    logic [7:0] d;
    logic [15:0] a;
    seed = $urandom(32'd2024);
    for (int i = 0; i < 4096; i++) exp_m[i] = 8'hFF;

    tick(5);
    check(sda_low == 1'b0, "R12 SDA released in reset", sda_low, 0);
    check(wr_valid == 1'b0 && wr_commit == 1'b0, "R12 no strobes in reset", {wr_valid, wr_commit}, 0);
    rst_n = 1'b1;
    tick(20);
    check(sda_low == 1'b0 && n_valid == 0, "R12 idle after reset", sda_low, 0);

    // R3: high nibble of first word byte ignored
    wbuf[0] = 8'h5A;
    do_write(16'hF123, 1);
    check(n_commit == 1 && n_valid == 1, "R4 one byte and one commit", n_commit * 16 + n_valid, 8'h11);
    // R9: polling while the engine works
    start_c(); send_byte(8'hA0, k); stop_c();
    check(!k, "R9 no ack while busy", k, 0);
    wait_ready(p);
    check(p >= 1 && p < 200, "R9 ack returns after write", p, 1);
    do_rread(16'h0123, 1, "R6 random read of written byte");

    // R5 page wrap
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33; wbuf[3] = 8'h44;
    do_write(16'h001E, 4);
    do_rread(16'h0000, 2, "R5 wrapped bytes at page start");
    do_rread(16'h001E, 2, "R5 bytes at page end");
    check(exp_ptr == 12'h020, "R7 pointer model", exp_ptr, 12'h020);
    do_cread(2, "R7 current read after read");
    do_rread(16'h0020, 1, "R5 next page untouched");

    // R7 after write
    wbuf[0] = 8'hA5; wbuf[1] = 8'h5A;
    do_write(16'h0040, 2);
    do_cread(1, "R7 current read after write");

    // R8 sequential wrap
    wbuf[0] = 8'hC3;
    do_write(16'h0FFF, 1);
    wbuf[0] = 8'h3C;
    do_write(16'h0000, 1);
    do_rread(16'h0FFE, 3, "R8 sequential wrap 0xFFF to 0x000");

    // R8 release after host nack
    wait_ready(p);
    start_c(); send_byte(8'hA0, k); send_byte(8'h00, k); send_byte(8'h40, k);
    start_c(); send_byte(8'hA1, k);
    get_byte(d, 1'b1);
    check(d == exp_m[12'h040], "R6 read before nack", d, exp_m[12'h040]);
    get_bit(b);
    check(b == 1'b1, "R8 no data after host nack", b, 1);
    stop_c();

    // R2 mismatching addresses
    vc = n_valid; cc = n_commit;
    start_c(); send_byte(8'hA2, k); check(!k, "R2 wrong low bits not acked", k, 0);
    send_byte(8'h00, k); check(!k, "R2 following byte ignored", k, 0);
    send_byte(8'h12, k); check(!k, "R2 following byte ignored", k, 0);
    stop_c();
    start_c(); send_byte(8'hB0, k); check(!k, "R2 wrong type code not acked", k, 0);
    stop_c();
    tick(10);
    check(n_valid == vc && n_commit == cc, "R2 nothing handed on", n_valid - vc, 0);

    // R10 cancel by start then stop
    start_c(); send_byte(8'hA0, k); send_byte(8'h00, k); send_byte(8'h50, k);
    send_bit(1'b0); send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
    start_c(); stop_c();
    start_c(); send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
    start_c(); stop_c();
    tick(BUSY + 50);
    check(n_commit == cc && n_valid == vc, "R10 no commit after abort", n_commit - cc, 0);
    ptr_ok = 1'b0;
    do_rread(16'h0050, 1, "R10 array unchanged after abort");

    // random mix
    for (int it = 0; it < 16; it++) begin
      op = $urandom % 3;
      a = 16'($urandom);
      if (op == 0) begin
        n = 1 + ($urandom % 8);
        for (int j = 0; j < n; j++) wbuf[j] = 8'($urandom);
        do_write(a, n);
      end else if (op == 1 || !ptr_ok) begin
        do_rread(a, 1 + ($urandom % 4), "R6 random read");
      end else begin
        do_cread(1 + ($urandom % 3), "R7 current read");
      end
    end

    tick(20);
    check(n_r11 == 0, "R11 SDA changed while SCL high", n_r11, 0);
    finish_run();
  end
endmodule